// File: doc/BRIEF.md
# CRTC Sync and Blank Generator

This block is the timing core of a display controller. It runs on the character clock, where one clock stands for eight pixels. A character counter sweeps each scanline. A line counter steps once at the end of every scanline. From these two counts and a bank of byte-wide indexed registers, the block derives horizontal and vertical sync, horizontal and vertical blank, a display-enable window and a one-cycle start-of-frame marker. It also forms a linear display address for the pixel fetch logic that follows it.

The registers use the compact encodings of classic PC display controllers:
- The horizontal total is stored minus five.
- The vertical total is stored minus two.
- Sync and blank ends are matched against only the low bits of their counter.
- The upper bits of the vertical values are gathered into a shared overflow byte.

Software makes a sync pulse disappear by writing a start value beyond the total. It selects scan doubling with a flag. A line-compare value makes the display address restart at zero part-way down the screen, which gives a split screen; the all-ones value turns this off.

Top module: `crtc_timing_gen`

## Requirements
- R1: The block resets synchronously on `rst_n` low. Out of reset both counters are 0 and the output values are hsync=0, vsync=0, hblank=0, vblank=0, disp_en=1, frame_start=1, disp_addr=0. The reset register values are: sync and blank starts 0xFF, overflow 0x9C, max-scan 0x60, line compare 0xFF, all other registers 0.
- R2: A scanline lasts (HTOTAL+5) character clocks. `disp_en` is high only for characters 0..HDISP of lines 0..VDISP.
- R3: `hsync` and `hblank` each go high in the cycle whose character count equals their start register. Each stays high until the first later character whose low 5 bits equal its end register, and that character is itself low. Bits 7:5 of the hblank end register are ignored.
- R4: A frame lasts (VTOTAL+2) scanlines, with 10-bit vertical values.
  - Overflow bit 0 is VTOTAL bit 8 and overflow bit 5 is VTOTAL bit 9.
  - Overflow bits 1 and 6 are bits 8 and 9 of VDISP.
  - Overflow bits 2 and 7 are bits 8 and 9 of vsync start.
  - Overflow bit 3 and max-scan bit 5 are bits 8 and 9 of vblank start.
- R5: `vsync` starts on the line equal to its start value and ends on the first later line whose low 4 bits equal the vsync end register. `vblank` works the same way but ends on an 8-bit match. Both flags change only at line boundaries and may continue across the frame wrap.
- R6: A sync or blank whose start value exceeds the counter's range never asserts. Start 0xFF with end 0 for hsync, and start 0x3FF with end 0 for vsync, give a blanked power-save state with no pulses.
- R7: `disp_addr` equals the 16-bit start address at character 0 of line 0. It rises by one per character. Each new scanline's base is the previous base plus twice the row-offset register.
- R8: With max-scan bit 7 set, the line base advances only on every second line, so each address row is shown twice.
- R9: The line compare value is 10 bits: the register, overflow bit 4 and max-scan bit 6.
  - The line after the one equal to this value starts at address 0 and restarts the doubling phase.
  - A value of 0x3FF disables this.
  - When the compare line is also the last line of the frame, the frame reload to the start address wins.
- R10: A write to the start-address registers takes effect at the next frame start and does not disturb the frame in progress.
- R11: `frame_start` is high exactly in the cycle at character 0 of line 0.
- R12: A write with `reg_we` high stores `reg_wdata` at index `reg_idx` on the clock edge. Indices above 0x11 are ignored. The index map is:

| Index | Register |
|---|---|
| 0x00 | HTOTAL |
| 0x01 | HDISP |
| 0x02 | hblank start |
| 0x03 | hblank end |
| 0x04 | hsync start |
| 0x05 | hsync end |
| 0x06 | VTOTAL low |
| 0x07 | overflow |
| 0x08 | max-scan |
| 0x09 | start address high |
| 0x0A | start address low |
| 0x0B | vsync start low |
| 0x0C | vsync end |
| 0x0D | VDISP low |
| 0x0E | vblank start low |
| 0x0F | vblank end |
| 0x10 | row offset |
| 0x11 | line compare low |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 8 | Register index |
| reg_wdata | input | 8 | Register write data |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| hblank | output | 1 | Horizontal blank |
| vblank | output | 1 | Vertical blank |
| disp_en | output | 1 | Active display window |
| frame_start | output | 1 | High at character 0 of line 0 |
| disp_addr | output | 16 | Linear display address |

## Verification
The address base has three sources that can compete at a single line end: the frame reload, the split-screen reset to zero, and the doubling hold. The bench provokes the frame/split clash by setting the line compare to the last line of an 18-line frame. It judges the result by requiring the following frame to begin at the start address rather than zero. A second collision arises when a blank or sync window spans the frame wrap while `frame_start` fires. That configuration is exercised with the vblank end placed two lines into the next frame, and every cycle of a whole frame is compared against an independent model.

// File: rtl/crtc_pkg.sv
// Package: shared widths, register indices, decoded configuration type and
// reset values for the CRTC sync and blank generator.
// Assumes the 10-bit vertical layout (register byte plus two extension bits).
package crtc_pkg;
    localparam int REG_W    = 8;
    localparam int IDX_W    = 8;
    localparam int NREGS    = 18;
    localparam int SEL_W    = $clog2(NREGS);
    localparam int HREG_W   = 8;
    localparam int VREG_W   = 10;
    localparam int HC_W     = HREG_W + 1;
    localparam int VC_W     = VREG_W + 1;
    localparam int HEND_W   = 5;
    localparam int VSEND_W  = 4;
    localparam int VBEND_W  = 8;
    localparam int ADDR_W   = 16;
    localparam int HBIAS    = 5;
    localparam int VBIAS    = 2;

    localparam int IX_HTOT   = 0;
    localparam int IX_HDISP  = 1;
    localparam int IX_HBS    = 2;
    localparam int IX_HBE    = 3;
    localparam int IX_HSS    = 4;
    localparam int IX_HSE    = 5;
    localparam int IX_VTOT   = 6;
    localparam int IX_OVF    = 7;
    localparam int IX_MSCAN  = 8;
    localparam int IX_STHI   = 9;
    localparam int IX_STLO   = 10;
    localparam int IX_VSS    = 11;
    localparam int IX_VSE    = 12;
    localparam int IX_VDISP  = 13;
    localparam int IX_VBS    = 14;
    localparam int IX_VBE    = 15;
    localparam int IX_ROWOFS = 16;
    localparam int IX_LCMP   = 17;

    typedef struct packed {
        logic [HREG_W-1:0]  htot;
        logic [HREG_W-1:0]  hdisp;
        logic [HREG_W-1:0]  hbs;
        logic [HEND_W-1:0]  hbe;
        logic [HREG_W-1:0]  hss;
        logic [HEND_W-1:0]  hse;
        logic [VREG_W-1:0]  vtot;
        logic [VREG_W-1:0]  vdisp;
        logic [VREG_W-1:0]  vss;
        logic [VSEND_W-1:0] vse;
        logic [VREG_W-1:0]  vbs;
        logic [VBEND_W-1:0] vbe;
        logic [VREG_W-1:0]  lcmp;
        logic               dbl;
        logic [ADDR_W-1:0]  start;
        logic [REG_W-1:0]   rowofs;
    } cfg_t;

    // Reset value of each indexed register: every start parked out of range.
    function automatic logic [REG_W-1:0] reg_reset_value(input int idx);
        case (idx)
            IX_HBS, IX_HSS, IX_VSS, IX_VBS, IX_LCMP: return 8'hFF;
            IX_OVF:                                  return 8'h9C;
            IX_MSCAN:                                return 8'h60;
            default:                                 return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/crtc_regs.sv
// Indexed register bank. Stores byte writes and decodes the bytes into the
// configuration fields, reassembling the 10-bit vertical values from the
// overflow and max-scan extension bits.
// Assumes one write per clock; out-of-range indices are dropped.
module crtc_regs
    import crtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [REG_W-1:0] wdata,
    output cfg_t             cfg
);
    logic [REG_W-1:0] bank [NREGS];
    logic [REG_W-1:0] ovf;
    logic [REG_W-1:0] msc;

    // Register storage: reset to parked values, then accept indexed writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) bank[i] <= reg_reset_value(i);
        end else if (we && (idx < IDX_W'(NREGS))) begin
            bank[idx[SEL_W-1:0]] <= wdata;
        end
    end

    assign ovf = bank[IX_OVF];
    assign msc = bank[IX_MSCAN];

    // Field decode, including the scattered vertical high bits.
    always_comb begin
        cfg.htot   = bank[IX_HTOT];
        cfg.hdisp  = bank[IX_HDISP];
        cfg.hbs    = bank[IX_HBS];
        cfg.hbe    = bank[IX_HBE][HEND_W-1:0];
        cfg.hss    = bank[IX_HSS];
        cfg.hse    = bank[IX_HSE][HEND_W-1:0];
        cfg.vtot   = {ovf[5], ovf[0], bank[IX_VTOT]};
        cfg.vdisp  = {ovf[6], ovf[1], bank[IX_VDISP]};
        cfg.vss    = {ovf[7], ovf[2], bank[IX_VSS]};
        cfg.vse    = bank[IX_VSE][VSEND_W-1:0];
        cfg.vbs    = {msc[5], ovf[3], bank[IX_VBS]};
        cfg.vbe    = bank[IX_VBE];
        cfg.lcmp   = {msc[6], ovf[4], bank[IX_LCMP]};
        cfg.dbl    = msc[7];
        cfg.start  = {bank[IX_STHI], bank[IX_STLO]};
        cfg.rowofs = bank[IX_ROWOFS];
    end
endmodule

// File: rtl/crtc_hcount.sv
// Character counter. Counts 0..HTOTAL+4 and flags the last character of
// each scanline. A total written below the current count wraps at once.
module crtc_hcount
    import crtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HREG_W-1:0] htot,
    input  logic [HREG_W-1:0] hdisp,
    output logic [HC_W-1:0]   hcnt,
    output logic              line_end,
    output logic              h_active
);
    assign line_end = hcnt >= (HC_W'(htot) + HC_W'(HBIAS - 1));
    assign h_active = hcnt <= HC_W'(hdisp);

    // Character count: step each clock, back to zero after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)        hcnt <= '0;
        else if (line_end) hcnt <= '0;
        else               hcnt <= hcnt + HC_W'(1);
    end
endmodule

// File: rtl/crtc_vcount.sv
// Line counter. Steps once per scanline, counting 0..VTOTAL+1, and flags
// the line end on which the frame wraps.
module crtc_vcount
    import crtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    input  logic [VREG_W-1:0] vtot,
    input  logic [VREG_W-1:0] vdisp,
    output logic [VC_W-1:0]   vcnt,
    output logic              frame_wrap,
    output logic              v_active
);
    assign frame_wrap = line_end && (vcnt >= (VC_W'(vtot) + VC_W'(VBIAS - 1)));
    assign v_active   = vcnt <= VC_W'(vdisp);

    // Line count: advance at each line end, restart at the frame wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)          vcnt <= '0;
        else if (frame_wrap) vcnt <= '0;
        else if (line_end)   vcnt <= vcnt + VC_W'(1);
    end

    // R4: the line count only moves on a line end from the character counter.
    a_r4_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> $stable(vcnt));
endmodule

// File: rtl/crtc_span.sv
// Generic sync/blank window. Goes active when the full count equals the
// start value and stays active, sampled on each advance, until the count's
// low END_W bits equal the end value. A start outside the count range
// therefore never activates the window.
module crtc_span #(
    parameter int CW = 9,
    parameter int SW = 8,
    parameter int EW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [CW-1:0] cnt,
    input  logic [SW-1:0] start_v,
    input  logic [EW-1:0] end_v,
    output logic          active
);
    logic held;
    logic hit;

    assign hit    = cnt == CW'(start_v);
    assign active = hit || (held && (cnt[EW-1:0] != end_v));

    // Window memory: captured on each advance step.
    always_ff @(posedge clk) begin
        if (!rst_n)   held <= 1'b0;
        else if (adv) held <= active;
    end

    // R6: an inactive window can only turn on through a start match.
    a_r6_rise_only_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!active || hit));
endmodule

// File: rtl/crtc_addr.sv
// Display address generator. Holds a line base that is loaded with the
// start address at the frame wrap, cleared after the line-compare line,
// held on the first line of a doubled pair, and otherwise stepped by twice
// the row offset. The output adds the character count to the base.
module crtc_addr
    import crtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    input  logic              frame_wrap,
    input  logic [HC_W-1:0]   hcnt,
    input  logic [VC_W-1:0]   vcnt,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [REG_W-1:0]  rowofs,
    input  logic [VREG_W-1:0] lcmp,
    input  logic              dbl,
    output logic [ADDR_W-1:0] disp_addr
);
    logic [ADDR_W-1:0] base;
    logic              rep_ph;
    logic              split_hit;

    assign split_hit = (lcmp != {VREG_W{1'b1}}) && (vcnt == VC_W'(lcmp));
    assign disp_addr = base + ADDR_W'(hcnt);

    // Line base update: frame reload outranks split reset, then doubling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base   <= '0;
            rep_ph <= 1'b0;
        end else if (line_end) begin
            if (frame_wrap) begin
                base   <= start_addr;
                rep_ph <= 1'b0;
            end else if (split_hit) begin
                base   <= '0;
                rep_ph <= 1'b0;
            end else if (dbl && !rep_ph) begin
                rep_ph <= 1'b1;
            end else begin
                base   <= base + ADDR_W'({rowofs, 1'b0});
                rep_ph <= 1'b0;
            end
        end
    end

    // R7: within a scanline the address climbs by one per character.
    a_r7_char_step: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> disp_addr == $past(disp_addr) + ADDR_W'(1));
    // R7: the first character of a frame shows the start address.
    a_r7_frame_load: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wrap |=> disp_addr == $past(start_addr));
    // R8: the first line of a doubled pair is repeated.
    a_r8_double_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && !frame_wrap && !split_hit && dbl && !rep_ph) |=> disp_addr == $past(base));
    // R9: the line after the compare line starts at address zero.
    a_r9_split_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && !frame_wrap && split_hit) |=> disp_addr == '0);
endmodule

// File: rtl/crtc_timing_gen.sv
// CRTC sync and blank generator top. Ties the register bank, the two
// counters, four window instances and the address generator together.
// Assumes clk is the character clock (8 pixels per tick); outputs are
// combinational from registered state.
module crtc_timing_gen
    import crtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic              hsync,
    output logic              vsync,
    output logic              hblank,
    output logic              vblank,
    output logic              disp_en,
    output logic              frame_start,
    output logic [ADDR_W-1:0] disp_addr
);
    cfg_t            cfg;
    logic [HC_W-1:0] hcnt;
    logic [VC_W-1:0] vcnt;
    logic            line_end;
    logic            frame_wrap;
    logic            h_active;
    logic            v_active;

    crtc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(reg_idx),
        .wdata(reg_wdata), .cfg(cfg)
    );

    crtc_hcount u_hcnt (
        .clk(clk), .rst_n(rst_n), .htot(cfg.htot), .hdisp(cfg.hdisp),
        .hcnt(hcnt), .line_end(line_end), .h_active(h_active)
    );

    crtc_vcount u_vcnt (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .vtot(cfg.vtot),
        .vdisp(cfg.vdisp), .vcnt(vcnt), .frame_wrap(frame_wrap),
        .v_active(v_active)
    );

    crtc_span #(.CW(HC_W), .SW(HREG_W), .EW(HEND_W)) u_hsync (
        .clk(clk), .rst_n(rst_n), .adv(1'b1), .cnt(hcnt),
        .start_v(cfg.hss), .end_v(cfg.hse), .active(hsync)
    );

    crtc_span #(.CW(HC_W), .SW(HREG_W), .EW(HEND_W)) u_hblank (
        .clk(clk), .rst_n(rst_n), .adv(1'b1), .cnt(hcnt),
        .start_v(cfg.hbs), .end_v(cfg.hbe), .active(hblank)
    );

    crtc_span #(.CW(VC_W), .SW(VREG_W), .EW(VSEND_W)) u_vsync (
        .clk(clk), .rst_n(rst_n), .adv(line_end), .cnt(vcnt),
        .start_v(cfg.vss), .end_v(cfg.vse), .active(vsync)
    );

    crtc_span #(.CW(VC_W), .SW(VREG_W), .EW(VBEND_W)) u_vblank (
        .clk(clk), .rst_n(rst_n), .adv(line_end), .cnt(vcnt),
        .start_v(cfg.vbs), .end_v(cfg.vbe), .active(vblank)
    );

    crtc_addr u_addr (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .frame_wrap(frame_wrap),
        .hcnt(hcnt), .vcnt(vcnt), .start_addr(cfg.start), .rowofs(cfg.rowofs),
        .lcmp(cfg.lcmp), .dbl(cfg.dbl), .disp_addr(disp_addr)
    );

    assign disp_en     = h_active && v_active;
    assign frame_start = (hcnt == '0) && (vcnt == '0);

    // R11: the frame marker never lasts two cycles (a line is at least 5).
    a_r11_single_marker: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);
endmodule

// File: tb/tb_crtc_timing_gen.sv
// Scoreboard bench: the driver programs a configuration, aligns on a frame
// marker and pushes one expected record per cycle for two frames (the
// first only aligns state); the monitor pops and compares at each negedge.
module tb_crtc_timing_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_idx = '0;
    logic [7:0]  reg_wdata = '0;
    logic        hsync, vsync, hblank, vblank, disp_en, frame_start;
    logic [15:0] disp_addr;

    int n_vec = 0;
    int n_bad = 0;
    string tag = "";

    typedef struct {
        logic        hs, vs, hb, vb, de, fs;
        logic [15:0] addr;
        bit          chk;
    } exp_t;
    exp_t q[$];

    logic [7:0] r [18];

    // model state
    int mh, mv, mbase;
    bit mhs, mhb, mvs, mvb, mph;

    always #10 clk = ~clk;

    crtc_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .hsync(hsync), .vsync(vsync), .hblank(hblank),
        .vblank(vblank), .disp_en(disp_en), .frame_start(frame_start),
        .disp_addr(disp_addr)
    );

    function automatic int ext10(input logic [7:0] lo, input logic b8, input logic b9);
        return int'(lo) + (b8 ? 256 : 0) + (b9 ? 512 : 0);
    endfunction
    function automatic int vtotal_f(); return ext10(r[6],  r[7][0], r[7][5]) + 2; endfunction
    function automatic int vdisp_f();  return ext10(r[13], r[7][1], r[7][6]); endfunction
    function automatic int vss_f();    return ext10(r[11], r[7][2], r[7][7]); endfunction
    function automatic int vbs_f();    return ext10(r[14], r[7][3], r[8][5]); endfunction
    function automatic int lc_f();     return ext10(r[17], r[7][4], r[8][6]); endfunction
    function automatic int start_f();  return int'({r[9], r[10]}); endfunction

    task automatic set_defaults();
        for (int i = 0; i < 18; i++) r[i] = 8'h00;
        r[2] = 8'hFF; r[4] = 8'hFF; r[11] = 8'hFF; r[14] = 8'hFF; r[17] = 8'hFF;
        r[7] = 8'h9C; r[8] = 8'h60;
    endtask

    // One model cycle: build the expected record, optionally queue it, advance.
    task automatic model_cycle(input bit push, input bit chk);
        exp_t e;
        int htotal = int'(r[0]) + 5;
        e.hs = (mh == int'(r[4])) || (mhs && (mh % 32) != (int'(r[5]) % 32));
        e.hb = (mh == int'(r[2])) || (mhb && (mh % 32) != (int'(r[3]) % 32));
        e.vs = (mv == vss_f()) || (mvs && (mv % 16) != (int'(r[12]) % 16));
        e.vb = (mv == vbs_f()) || (mvb && (mv % 256) != int'(r[15]));
        e.de = (mh <= int'(r[1])) && (mv <= vdisp_f());
        e.fs = (mh == 0) && (mv == 0);
        e.addr = 16'((mbase + mh) % 65536);
        e.chk = chk;
        if (push) q.push_back(e);
        mhs = e.hs; mhb = e.hb;
        if (mh == htotal - 1) begin
            mvs = e.vs; mvb = e.vb; mh = 0;
            if (mv == vtotal_f() - 1) begin
                mv = 0; mbase = start_f(); mph = 0;
            end else if (lc_f() != 1023 && mv == lc_f()) begin
                mbase = 0; mph = 0; mv++;
            end else if (r[8][7] && !mph) begin
                mph = 1; mv++;
            end else begin
                mbase = (mbase + 2 * int'(r[16])) % 65536; mph = 0; mv++;
            end
        end else begin
            mh++;
        end
    endtask

    task automatic note(input string req, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        set_defaults();
    endtask

    task automatic wr(input int idx, input logic [7:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = 8'(idx); reg_wdata = val;
        if (idx < 18) r[idx] = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_frame();
        @(negedge clk);
        while (!frame_start) @(negedge clk);
    endtask

    // Align on a frame marker, then queue one silent frame and one checked frame.
    task automatic run_cfg(input string t);
        int flen;
        tag = t;
        repeat (3) @(negedge clk);
        wait_frame();
        #1;
        mh = 0; mv = 0; mhs = 0; mhb = 0; mvs = 0; mvb = 0; mph = 0;
        mbase = start_f();
        flen = (int'(r[0]) + 5) * vtotal_f();
        model_cycle(1'b0, 1'b0);
        for (int i = 1; i < flen; i++) model_cycle(1'b1, 1'b0);
        for (int i = 0; i < flen; i++) model_cycle(1'b1, 1'b1);
        wait (q.size() == 0);
    endtask

    // Monitor: pop one expected record per cycle and compare.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            if (e.chk) begin
                n_vec++;
                if ({hsync, vsync, hblank, vblank, disp_en, frame_start, disp_addr} !==
                    {e.hs, e.vs, e.hb, e.vb, e.de, e.fs, e.addr}) begin
                    n_bad++;
                    $display("FAIL %s hs/vs/hb/vb/de/fs/addr got=%b%b%b%b%b%b/%h expected=%b%b%b%b%b%b/%h",
                             tag, hsync, vsync, hblank, vblank, disp_en, frame_start, disp_addr,
                             e.hs, e.vs, e.hb, e.vb, e.de, e.fs, e.addr);
                end
            end
        end
    end

    task automatic base_cfg();
        wr(0, 8'd15);  wr(1, 8'd9);   wr(2, 8'd10); wr(3, 8'h92);
        wr(4, 8'd12);  wr(5, 8'd16);  wr(6, 8'd10); wr(7, 8'h10);
        wr(8, 8'h40);  wr(9, 8'h12);  wr(10, 8'h34); wr(11, 8'd9);
        wr(12, 8'd10); wr(13, 8'd7);  wr(14, 8'd8); wr(15, 8'd11);
        wr(16, 8'd5);  wr(17, 8'hFF);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired got=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : driver
        int old_start;
        set_defaults();
        // R1: reset state
        do_reset();
        #1;
        note("R1 hsync", hsync, 0);   note("R1 vsync", vsync, 0);
        note("R1 hblank", hblank, 0); note("R1 vblank", vblank, 0);
        note("R1 disp_en", disp_en, 1); note("R1 frame_start", frame_start, 1);
        note("R1 disp_addr", disp_addr, 0);

        // R2 R3 R4 R5 R7 R11 R12: baseline timing, index map
        base_cfg();
        wr(8'h2A, 8'h55); // R12: out-of-range index must change nothing
        run_cfg("R2/R3/R4/R5/R7/R11/R12 baseline");

        // R10: mid-frame start address write, seen only at the next frame
        old_start = start_f();
        wait_frame();
        repeat (25) @(negedge clk);
        reg_we = 1'b1; reg_idx = 8'd9; reg_wdata = 8'hAB; r[9] = 8'hAB;
        @(negedge clk);
        reg_idx = 8'd10; reg_wdata = 8'hCD; r[10] = 8'hCD;
        @(negedge clk);
        reg_we = 1'b0;
        @(negedge clk);
        note("R10 current frame keeps old base", disp_addr, (old_start + 10 + 8) % 65536);
        wait_frame();
        note("R10 next frame uses new start", disp_addr, 16'hABCD);

        // R3 R5: truncated ends wrapping past start, spans crossing the frame wrap
        do_reset();
        wr(0, 8'd40); wr(1, 8'd31); wr(2, 8'd30); wr(3, 8'hE5);
        wr(4, 8'd14); wr(5, 8'h02); wr(6, 8'd22); wr(7, 8'h10); wr(8, 8'h40);
        wr(11, 8'd12); wr(12, 8'h13); wr(13, 8'd18); wr(14, 8'd20); wr(15, 8'd2);
        wr(16, 8'd20); wr(9, 8'h40); wr(10, 8'h00);
        run_cfg("R3/R5 truncated ends");

        // R4 R5: overflow bits for 10-bit vertical values
        do_reset();
        wr(0, 8'd0); wr(1, 8'd2); wr(6, 8'h01); wr(7, 8'hBA); wr(8, 8'h40);
        wr(13, 8'hF0); wr(11, 8'h00); wr(12, 8'h02); wr(14, 8'h50); wr(15, 8'h60);
        wr(16, 8'd1);
        run_cfg("R4/R5 overflow bits");

        // R8 R9: scan doubling with split screen at line 5
        do_reset();
        wr(0, 8'd7); wr(1, 8'd7); wr(6, 8'd16); wr(7, 8'h8C); wr(8, 8'hA0);
        wr(13, 8'd15); wr(16, 8'd3); wr(9, 8'h01); wr(10, 8'h00); wr(17, 8'd5);
        run_cfg("R8/R9 doubling and split");

        // R9: split line equals last line, frame reload wins
        wr(17, 8'd17);
        run_cfg("R9 split on last line");

        // R6: power-save, both syncs parked
        do_reset();
        base_cfg();
        wr(4, 8'hFF); wr(5, 8'h00); wr(11, 8'hFF); wr(12, 8'h00); wr(7, 8'h94);
        run_cfg("R6 sync suppression");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule